// File: doc/BRIEF.md
# Memory Request Scheduler with Ordering Barriers

This block sits between a system bus and a DRAM command issuer. It accepts posted memory reads and writes, gives each one an arrival number, and keeps up to eight of them in a small queue. In normal operation it sends them downstream out of order so that requests hitting a row already open in their bank go first. Among requests that are equally good on that count, the oldest goes first.

Two controls limit this reordering. A mode input forces strict arrival order for the whole queue. Any access to the controller's own configuration space acts as a local barrier. A configuration write is a posted barrier and produces no answer. A configuration read is a reporting barrier: it returns a fixed data word in a one-cycle response pulse once every memory request accepted before it has been handed downstream. Requests accepted after the read may still be queued when the response goes out.

The downstream side is a plain valid/ready handshake that carries the direction, the address and the arrival number of the chosen request.

Top module: `mreq_sched`

## Requirements
- R1: `req_kind_i` uses these codes: 2'b00 memory read, 2'b01 memory write, 2'b10 configuration read, 2'b11 configuration write. Memory requests are queued, up to 8 at a time. `req_ready_o` is low while 8 are queued and returns high once one has issued.
- R2: While `in_order_i` is high, requests issue in exactly the order they were accepted, whatever their row status.
- R3: While `in_order_i` is low, an eligible request that hits the open row of its bank is chosen before an older eligible request that misses. The address fields are: column = addr[3:0], bank = addr[5:4], row = addr[15:6].
- R4: Among eligible requests with the same row-hit status, the oldest is chosen first.
- R5: Two requests to the same address always issue in acceptance order.
- R6: A configuration write is a barrier. Every memory request accepted before it issues before any request accepted after it, and no response is produced.
- R7: A configuration read applies the same barrier. `rsp_valid_o` pulses for exactly one cycle with `rsp_data_o` = 32'h5EC0_0D01, and only after every memory request accepted before the read has issued. No response comes while any of them is still queued.
- R8: Only one configuration read is outstanding at a time. While one waits, `req_ready_o` is low when a configuration read is presented and stays available for memory requests.
- R9: After reset, `req_ready_o` is high, `iss_valid_o` and `rsp_valid_o` are low, and no bank has an open row, so the first requests are ordered by age alone.
- R10: An issue presents the request's write flag, address and arrival number. Arrival numbers count accepted memory requests from 0 after reset and wrap at 256. An issue completes when `iss_valid_o` and `iss_ready_i` are both high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_order_i | input | 1 | Force strict arrival order |
| req_valid_i | input | 1 | Bus request valid |
| req_ready_o | output | 1 | Bus request accepted when high with valid |
| req_kind_i | input | 2 | Request kind code |
| req_addr_i | input | 16 | Request address |
| iss_valid_o | output | 1 | A request is offered downstream |
| iss_ready_i | input | 1 | Downstream takes the offered request |
| iss_write_o | output | 1 | Offered request is a write |
| iss_addr_o | output | 16 | Offered request address |
| iss_seq_o | output | 8 | Arrival number of the offered request |
| rsp_valid_o | output | 1 | Configuration read response pulse |
| rsp_data_o | output | 32 | Configuration read response data |

## Verification
The directed scenarios set up open rows so that each ordering rule conflicts with the row-hit preference. A younger row hit placed behind a posted or reporting barrier would overtake the older miss if the barrier were ignored. In forced-order mode the same layout would come out hit-first if the mode bit were dropped. Right after reset, a scheduler that treated row zero as open would issue a younger request first. The reporting barrier is held off by stalling the downstream side, which exposes a response sent too early, one sent twice or one held for more than a cycle. The bench also checks that a second configuration read is refused without blocking memory traffic. A full queue shows whether ready drops at eight entries.

// File: rtl/mreq_pkg.sv
package mreq_pkg;
  typedef enum logic [1:0] {
    K_MEM_RD = 2'b00,
    K_MEM_WR = 2'b01,
    K_CFG_RD = 2'b10,
    K_CFG_WR = 2'b11
  } req_kind_e;
endpackage

// File: rtl/mreq_slots.sv
// Request storage with per-entry dependency and age matrices.
module mreq_slots #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_i,
  input  logic [AW-1:0]    enq_addr_i,
  input  logic             enq_wr_i,
  input  logic [SEQ_W-1:0] enq_seq_i,
  input  logic             fence_i,
  input  logic [DEPTH-1:0] deq_oh_i,
  output logic [DEPTH-1:0] valid_o,
  output logic [AW-1:0]    addr_o [DEPTH],
  output logic [DEPTH-1:0] wr_o,
  output logic [SEQ_W-1:0] seq_o [DEPTH],
  output logic [DEPTH-1:0] free_dep_o,
  output logic [DEPTH-1:0] older_o [DEPTH],
  output logic             full_o
);
  logic [DEPTH-1:0] vld_q, vld_n, bar_q, bar_n, keep, same, slot_oh;
  logic [DEPTH-1:0] dep_q [DEPTH];
  logic [DEPTH-1:0] dep_n [DEPTH];
  logic [DEPTH-1:0] old_q [DEPTH];
  logic [DEPTH-1:0] old_n [DEPTH];
  logic [AW-1:0]    addr_q [DEPTH];
  logic [SEQ_W-1:0] seq_q  [DEPTH];
  logic [DEPTH-1:0] wr_q;

  assign keep    = vld_q & ~deq_oh_i;
  assign slot_oh = ~vld_q & (vld_q + DEPTH'(1));
  assign full_o  = &vld_q;
  assign valid_o = vld_q;
  assign wr_o    = wr_q;

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      same[j] = vld_q[j] && (addr_q[j] == enq_addr_i);
    end
  end

  always_comb begin
    vld_n = keep;
    bar_n = bar_q & ~deq_oh_i;
    for (int i = 0; i < DEPTH; i++) begin
      dep_n[i] = dep_q[i] & ~deq_oh_i;
      old_n[i] = old_q[i] & ~deq_oh_i;
    end
    if (fence_i) bar_n = keep;
    if (enq_i) begin
      vld_n = vld_n | slot_oh;
      bar_n = bar_n & ~slot_oh;
      for (int i = 0; i < DEPTH; i++) begin
        if (slot_oh[i]) begin
          dep_n[i] = keep & (bar_q | same);
          old_n[i] = keep;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      bar_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        dep_q[i] <= '0;
        old_q[i] <= '0;
      end
    end else begin
      vld_q <= vld_n;
      bar_q <= bar_n;
      for (int i = 0; i < DEPTH; i++) begin
        dep_q[i] <= dep_n[i];
        old_q[i] <= old_n[i];
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_payload
    always_ff @(posedge clk) begin
      if (enq_i && slot_oh[g]) begin
        addr_q[g] <= enq_addr_i;
        seq_q[g]  <= enq_seq_i;
        wr_q[g]   <= enq_wr_i;
      end
    end
    assign addr_o[g]     = addr_q[g];
    assign seq_o[g]      = seq_q[g];
    assign older_o[g]    = old_q[g];
    assign free_dep_o[g] = vld_q[g] && (dep_q[g] == '0);
  end
endmodule

// File: rtl/mreq_rows.sv
// Open-row table per bank and row-hit flags for queued entries.
module mreq_rows #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank_i [DEPTH],
  input  logic [ROW_W-1:0]  row_i  [DEPTH],
  input  logic              upd_i,
  input  logic [BANK_W-1:0] upd_bank_i,
  input  logic [ROW_W-1:0]  upd_row_i,
  output logic [DEPTH-1:0]  hit_o
);
  localparam int NBANK = 1 << BANK_W;
  logic [ROW_W-1:0] open_row_q [NBANK];
  logic [NBANK-1:0] open_ok_q, open_ok_n;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hit_o[i] = open_ok_q[bank_i[i]] && (open_row_q[bank_i[i]] == row_i[i]);
    end
  end

  always_comb begin
    open_ok_n = open_ok_q;
    if (upd_i) open_ok_n[upd_bank_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_ok_q <= '0;
    else        open_ok_q <= open_ok_n;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (upd_i && (upd_bank_i == BANK_W'(b))) open_row_q[b] <= upd_row_i;
    end
  end
endmodule

// File: rtl/mreq_pick.sv
// Chooses one eligible entry: row hits first unless strict order, then oldest.
module mreq_pick #(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0] elig_i,
  input  logic [DEPTH-1:0] hit_i,
  input  logic [DEPTH-1:0] older_i [DEPTH],
  input  logic             in_order_i,
  output logic [DEPTH-1:0] pick_oh_o
);
  logic [DEPTH-1:0] hits, cand;

  assign hits = elig_i & hit_i;
  assign cand = (in_order_i || (hits == '0)) ? elig_i : hits;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      pick_oh_o[i] = cand[i] && ((older_i[i] & cand) == '0);
    end
  end
endmodule

// File: rtl/mreq_sched.sv
module mreq_sched
  import mreq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int AW     = 16,
  parameter int COL_W  = 4,
  parameter int BANK_W = 2,
  parameter int SEQ_W  = 8,
  parameter int RSP_W  = 32,
  parameter logic [RSP_W-1:0] RSP_VAL = 32'h5EC0_0D01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_order_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [1:0]       req_kind_i,
  input  logic [AW-1:0]    req_addr_i,
  output logic             iss_valid_o,
  input  logic             iss_ready_i,
  output logic             iss_write_o,
  output logic [AW-1:0]    iss_addr_o,
  output logic [SEQ_W-1:0] iss_seq_o,
  output logic             rsp_valid_o,
  output logic [RSP_W-1:0] rsp_data_o
);
  localparam int ROW_W = AW - COL_W - BANK_W;

  req_kind_e        kind;
  logic             acc, enq, fence, rd_acc, full, iss_fire;
  logic [SEQ_W-1:0] seq_q, seq_n;
  logic [DEPTH-1:0] vld, wr, elig, hit, pick, deq;
  logic [AW-1:0]    eaddr [DEPTH];
  logic [SEQ_W-1:0] eseq  [DEPTH];
  logic [DEPTH-1:0] older [DEPTH];
  logic [BANK_W-1:0] ebank [DEPTH];
  logic [ROW_W-1:0]  erow  [DEPTH];
  logic             rdp_q, rdp_n, rsp_q, rsp_n;
  logic [DEPTH-1:0] wait_q, wait_n;

  assign kind        = req_kind_e'(req_kind_i);
  assign req_ready_o = !full && !(rdp_q && (kind == K_CFG_RD));
  assign acc         = req_valid_i && req_ready_o;
  assign enq         = acc && !req_kind_i[1];
  assign fence       = acc && req_kind_i[1];
  assign rd_acc      = acc && (kind == K_CFG_RD);
  assign iss_valid_o = |pick;
  assign iss_fire    = iss_valid_o && iss_ready_i;
  assign deq         = pick & {DEPTH{iss_ready_i}};
  assign rsp_valid_o = rsp_q;
  assign rsp_data_o  = rsp_q ? RSP_VAL : '0;

  mreq_slots #(.DEPTH(DEPTH), .AW(AW), .SEQ_W(SEQ_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .enq_i(enq), .enq_addr_i(req_addr_i), .enq_wr_i(kind == K_MEM_WR),
    .enq_seq_i(seq_q), .fence_i(fence), .deq_oh_i(deq),
    .valid_o(vld), .addr_o(eaddr), .wr_o(wr), .seq_o(eseq),
    .free_dep_o(elig), .older_o(older), .full_o(full)
  );

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ebank[i] = eaddr[i][COL_W +: BANK_W];
      erow[i]  = eaddr[i][COL_W+BANK_W +: ROW_W];
    end
  end

  mreq_rows #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n),
    .bank_i(ebank), .row_i(erow),
    .upd_i(iss_fire),
    .upd_bank_i(iss_addr_o[COL_W +: BANK_W]),
    .upd_row_i(iss_addr_o[COL_W+BANK_W +: ROW_W]),
    .hit_o(hit)
  );

  mreq_pick #(.DEPTH(DEPTH)) u_pick (
    .elig_i(elig), .hit_i(hit), .older_i(older),
    .in_order_i(in_order_i), .pick_oh_o(pick)
  );

  always_comb begin
    iss_write_o = 1'b0;
    iss_addr_o  = '0;
    iss_seq_o   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (pick[i]) begin
        iss_write_o = wr[i];
        iss_addr_o  = eaddr[i];
        iss_seq_o   = eseq[i];
      end
    end
  end

  always_comb begin
    seq_n  = seq_q;
    wait_n = wait_q & ~deq;
    rdp_n  = rdp_q;
    rsp_n  = 1'b0;
    if (enq) seq_n = seq_q + SEQ_W'(1);
    if (rd_acc) begin
      wait_n = vld & ~deq;
      rdp_n  = 1'b1;
    end else if (rdp_q && (wait_q == '0)) begin
      rdp_n = 1'b0;
      rsp_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= '0;
      wait_q <= '0;
      rdp_q  <= 1'b0;
      rsp_q  <= 1'b0;
    end else begin
      seq_q  <= seq_n;
      wait_q <= wait_n;
      rdp_q  <= rdp_n;
      rsp_q  <= rsp_n;
    end
  end
endmodule

// File: rtl/mreq_sched_chk.sv
module mreq_sched_chk #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8,
  parameter int RSP_W = 32,
  parameter logic [RSP_W-1:0] RSP_VAL = 32'h5EC0_0D01
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_order_i,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [1:0]       req_kind_i,
  input logic             iss_valid_o,
  input logic             iss_ready_i,
  input logic [SEQ_W-1:0] iss_seq_o,
  input logic             rsp_valid_o,
  input logic [RSP_W-1:0] rsp_data_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          enq_c, iss_c, rdacc_c, old_iss;
  logic [CW-1:0] outst_q, left_q;
  logic [SEQ_W-1:0] nseq_q, exp_q, mark_q, diff;
  logic          strict_q, rdon_q;

  assign enq_c   = req_valid_i && req_ready_o && !req_kind_i[1];
  assign iss_c   = iss_valid_o && iss_ready_i;
  assign rdacc_c = req_valid_i && req_ready_o && (req_kind_i == 2'b10);
  assign diff    = iss_seq_o - mark_q;
  assign old_iss = iss_c && diff[SEQ_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q  <= '0;
      nseq_q   <= '0;
      exp_q    <= '0;
      mark_q   <= '0;
      left_q   <= '0;
      strict_q <= 1'b1;
      rdon_q   <= 1'b0;
    end else begin
      outst_q <= outst_q + CW'(enq_c) - CW'(iss_c);
      if (enq_c) nseq_q <= nseq_q + SEQ_W'(1);
      if (iss_c) exp_q <= exp_q + SEQ_W'(1);
      if (!in_order_i) strict_q <= 1'b0;
      if (rdacc_c) begin
        mark_q <= nseq_q;
        left_q <= outst_q - CW'(iss_c);
        rdon_q <= 1'b1;
      end else begin
        if (old_iss && (left_q != '0)) left_q <= left_q - CW'(1);
        if (rsp_valid_o) rdon_q <= 1'b0;
      end
    end
  end

  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (outst_q == CW'(DEPTH)) |-> !req_ready_o); // R1
  AST_NO_EMPTY_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid_o |-> (outst_q != '0)); // R10
  AST_STRICT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (strict_q && in_order_i && iss_c) |-> (iss_seq_o == exp_q)); // R2
  AST_RSP_AFTER_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> (left_q == '0)); // R7
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o); // R7
  AST_RSP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> (rsp_data_o == RSP_VAL)); // R7
  AST_ONE_CFG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rdon_q && (req_kind_i == 2'b10)) |-> !req_ready_o); // R8
endmodule

bind mreq_sched mreq_sched_chk #(
  .DEPTH(DEPTH), .SEQ_W(SEQ_W), .RSP_W(RSP_W), .RSP_VAL(RSP_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_order_i(in_order_i),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_kind_i(req_kind_i),
  .iss_valid_o(iss_valid_o), .iss_ready_i(iss_ready_i), .iss_seq_o(iss_seq_o),
  .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o)
);

// File: tb/tb_mreq_sched.sv
module tb_mreq_sched;
  logic        clk, rst_n, in_order, req_valid, req_ready;
  logic [1:0]  req_kind;
  logic [15:0] req_addr, iss_addr;
  logic        iss_valid, iss_ready, iss_write, rsp_valid;
  logic [7:0]  iss_seq;
  logic [31:0] rsp_data, rsp_d;

  int tests, fails, nlog, nrsp, rsp_at, bseq;
  logic [7:0]  lseq  [256];
  logic [15:0] laddr [256];
  logic        lwr   [256];

  mreq_sched dut (
    .clk(clk), .rst_n(rst_n), .in_order_i(in_order),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_kind_i(req_kind),
    .req_addr_i(req_addr), .iss_valid_o(iss_valid), .iss_ready_i(iss_ready),
    .iss_write_o(iss_write), .iss_addr_o(iss_addr), .iss_seq_o(iss_seq),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rsp_valid) begin
      nrsp   = nrsp + 1;
      rsp_at = nlog;
      rsp_d  = rsp_data;
    end
    if (iss_valid && iss_ready) begin
      lseq[nlog[7:0]]  = iss_seq;
      laddr[nlog[7:0]] = iss_addr;
      lwr[nlog[7:0]]   = iss_write;
      nlog = nlog + 1;
    end
  end

  function automatic logic [15:0] mk(int row, int bank, int col);
    return {row[9:0], bank[1:0], col[3:0]};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [15:0] a, output int s);
    req_kind  = k;
    req_addr  = a;
    req_valid = 1'b1;
    s = bseq;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (!k[1]) bseq++;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain(input int target);
    do @(posedge clk); while (nlog < target);
    #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready after reset", 32'(req_ready), 1);
    chk(iss_valid == 1'b0, "R9", "issue valid after reset", 32'(iss_valid), 0);
    chk(rsp_valid == 1'b0, "R9", "response after reset", 32'(rsp_valid), 0);
    @(posedge clk); #1;
  endtask

  task automatic t_age;
    int s, a, b, c;
    s = nlog;
    iss_ready = 1'b0;
    send(2'b01, mk(5, 0, 0), a);
    send(2'b00, mk(0, 0, 1), b);
    send(2'b00, mk(7, 1, 0), c);
    iss_ready = 1'b1;
    drain(s + 3);
    iss_ready = 1'b0;
    chk(lseq[s] == 8'(a), "R9", "no open row at reset, first issue", 32'(lseq[s]), 32'(a));
    chk(lseq[s+1] == 8'(b), "R4", "second by age", 32'(lseq[s+1]), 32'(b));
    chk(lseq[s+2] == 8'(c), "R4", "third by age", 32'(lseq[s+2]), 32'(c));
    chk(laddr[s] == mk(5, 0, 0), "R10", "issued address", 32'(laddr[s]), 32'(mk(5, 0, 0)));
    chk(lwr[s] == 1'b1 && lwr[s+1] == 1'b0, "R10", "write flags", {lwr[s], lwr[s+1]}, 2);
    chk(a == 0, "R10", "first arrival number", 32'(a), 0);
  endtask

  task automatic t_rowhit;
    int s, p, q, r;
    s = nlog;
    send(2'b00, mk(3, 0, 2), p);
    send(2'b01, mk(0, 0, 3), q);
    send(2'b00, mk(9, 2, 0), r);
    iss_ready = 1'b1;
    drain(s + 3);
    iss_ready = 1'b0;
    chk(lseq[s] == 8'(q), "R3", "row hit overtakes", 32'(lseq[s]), 32'(q));
    chk(lseq[s+1] == 8'(p), "R4", "older miss next", 32'(lseq[s+1]), 32'(p));
    chk(lseq[s+2] == 8'(r), "R4", "youngest miss last", 32'(lseq[s+2]), 32'(r));
  endtask

  task automatic t_same;
    int s, xw, xr, z;
    s = nlog;
    send(2'b01, mk(4, 1, 5), xw);
    send(2'b00, mk(4, 1, 5), xr);
    send(2'b00, mk(3, 0, 6), z);
    iss_ready = 1'b1;
    drain(s + 3);
    iss_ready = 1'b0;
    chk(lseq[s] == 8'(z), "R3", "hit first", 32'(lseq[s]), 32'(z));
    chk(lseq[s+1] == 8'(xw), "R5", "same address write first", 32'(lseq[s+1]), 32'(xw));
    chk(lseq[s+2] == 8'(xr), "R5", "same address read second", 32'(lseq[s+2]), 32'(xr));
  endtask

  task automatic t_wbar;
    int s, n0, p, d, q;
    s = nlog;
    n0 = nrsp;
    send(2'b00, mk(8, 0, 0), p);
    send(2'b11, 16'h0000, d);
    send(2'b01, mk(3, 0, 1), q);
    iss_ready = 1'b1;
    drain(s + 2);
    iss_ready = 1'b0;
    idle(3);
    chk(lseq[s] == 8'(p), "R6", "older miss before barrier", 32'(lseq[s]), 32'(p));
    chk(lseq[s+1] == 8'(q), "R6", "younger hit after barrier", 32'(lseq[s+1]), 32'(q));
    chk(nrsp == n0, "R6", "posted barrier gives no response", 32'(nrsp), 32'(n0));
  endtask

  task automatic t_rbar;
    int s, n0, p, d, q;
    s = nlog;
    n0 = nrsp;
    send(2'b00, mk(6, 0, 0), p);
    send(2'b10, 16'h0000, d);
    idle(5);
    chk(nrsp == n0, "R7", "no response while older queued", 32'(nrsp), 32'(n0));
    req_kind = 2'b10;
    @(negedge clk);
    chk(req_ready == 1'b0, "R8", "second config read refused", 32'(req_ready), 0);
    req_kind = 2'b00;
    #1;
    chk(req_ready == 1'b1, "R8", "memory request still accepted", 32'(req_ready), 1);
    @(posedge clk); #1;
    send(2'b00, mk(3, 0, 2), q);
    idle(3);
    chk(nrsp == n0, "R7", "still no response", 32'(nrsp), 32'(n0));
    iss_ready = 1'b1;
    drain(s + 2);
    iss_ready = 1'b0;
    idle(4);
    chk(lseq[s] == 8'(p), "R7", "older miss before read barrier", 32'(lseq[s]), 32'(p));
    chk(lseq[s+1] == 8'(q), "R7", "younger hit after read barrier", 32'(lseq[s+1]), 32'(q));
    chk(nrsp == n0 + 1, "R7", "one response cycle", 32'(nrsp), 32'(n0 + 1));
    chk(rsp_d == 32'h5EC0_0D01, "R7", "response data", rsp_d, 32'h5EC0_0D01);
    chk(rsp_at >= s + 1, "R7", "older issued before response", 32'(rsp_at), 32'(s + 1));
    req_kind = 2'b10;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8", "config read accepted again", 32'(req_ready), 1);
    req_kind = 2'b00;
    @(posedge clk); #1;
  endtask

  task automatic t_inorder;
    int s, a, b, c, d;
    s = nlog;
    in_order = 1'b1;
    send(2'b00, mk(11, 0, 0), a);
    send(2'b01, mk(3, 0, 1), b);
    send(2'b00, mk(12, 3, 0), c);
    send(2'b00, mk(11, 0, 4), d);
    iss_ready = 1'b1;
    drain(s + 4);
    iss_ready = 1'b0;
    in_order = 1'b0;
    chk(lseq[s] == 8'(a), "R2", "strict 1st", 32'(lseq[s]), 32'(a));
    chk(lseq[s+1] == 8'(b), "R2", "strict 2nd", 32'(lseq[s+1]), 32'(b));
    chk(lseq[s+2] == 8'(c), "R2", "strict 3rd", 32'(lseq[s+2]), 32'(c));
    chk(lseq[s+3] == 8'(d), "R2", "strict 4th", 32'(lseq[s+3]), 32'(d));
  endtask

  task automatic t_full;
    int s, x;
    s = nlog;
    for (int i = 0; i < 8; i++) send(2'b01, mk(20 + i, i % 4, 0), x);
    req_kind = 2'b00;
    @(negedge clk);
    chk(req_ready == 1'b0, "R1", "ready low with 8 queued", 32'(req_ready), 0);
    @(posedge clk); #1;
    iss_ready = 1'b1;
    drain(s + 8);
    iss_ready = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready back after drain", 32'(req_ready), 1);
    chk(nlog - s == 8, "R1", "all eight issued", 32'(nlog - s), 8);
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0; nlog = 0; nrsp = 0; rsp_at = 0; bseq = 0;
    rsp_d = '0;
    in_order = 1'b0; req_valid = 1'b0; req_kind = 2'b00; req_addr = '0;
    iss_ready = 1'b0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_age;
    t_rowhit;
    t_same;
    t_wbar;
    t_rbar;
    t_inorder;
    t_full;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule